// File: doc/BRIEF.md
# MSI Event Queue Writer

This block turns message-signalled interrupts into records in host memory. Every MSI that arrives names a target queue and carries a 16-bit payload. The block packs the payload into a 32-bit word and writes that word to the next free slot of the chosen queue. Each queue is a ring of 64 words held in host memory. The block issues the write through a simple request/acknowledge master. Once the write is acknowledged, it moves that queue's tail forward. Each queue drives one interrupt line, and that line stays high for as long as unread records remain.

Software programs the base address of each ring through a small register port. It reads the tail to learn how far the hardware has written. After it has consumed records, it writes the head. The hardware moves only the tails, and software moves only the heads. When a ring has no free slot, the MSI channel stalls until software frees one. MSIs are handled strictly one at a time, in the order they arrive, whatever queue they target.

Top module: `msi_evq_writer`

## Requirements
- R1: After reset all heads and tails read 0, every irq bit is 0, mem_req is 0, and msi_ready is 1.
- R2: Each written entry has the MSI data in bits 15:0 and zero in bits 31:16.
- R3: The entry address is the queue's base plus 4 times its tail. The tail advances by one per acknowledged entry and wraps from 63 to 0, so the slot after offset 252 is offset 0.
- R4: mem_req stays high with mem_addr and mem_wdata stable until mem_ack is seen. Only one write is outstanding, and msi_ready is 0 while it is pending.
- R5: A queue's tail, as read through the register port, keeps its old value until the entry's write has been acknowledged.
- R6: irq[q] is 1 exactly when head[q] differs from tail[q]. It rises in the cycle after the acknowledge and falls once software writes a head equal to the tail.
- R7: A queue is full when tail+1 equals head (mod 64), so it holds at most 63 entries. An MSI to a full queue sees msi_ready at 0 and causes no write until the head is advanced. MSIs to other queues see msi_ready at 1.
- R8: MSIs are written in arrival order across queues. Each MSI goes only to its own ring and raises only its own irq bit.
- R9: reg_addr is {queue, field}. Field 0 is the base (read/write, full width). Field 1 is the head (read/write, low 6 bits). Field 2 is the tail (read-only, so writes to it are ignored). Field 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msi_valid | input | 1 | MSI offered |
| msi_ready | output | 1 | MSI accepted at this edge when high with valid |
| msi_queue | input | 2 | Target queue index |
| msi_data | input | 16 | MSI payload |
| mem_req | output | 1 | Memory write request |
| mem_ack | input | 1 | Memory write acknowledge |
| mem_addr | output | 32 | Byte address of entry |
| mem_wdata | output | 32 | Entry word |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | {queue, field} select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 4 | Per-queue level interrupt |

## Verification
The bench holds the acknowledge back and confirms three things: the request and its address do not move, the channel stays closed, and the tail does not advance early. A design that bumped the tail on issue would let software read an entry that has not landed. The bench fills one ring to 63 entries across the 63-to-0 wrap and then checks for a stall. A design with an off-by-one full test would overwrite the unread head entry, or would write to base+256. It also interleaves queues under delayed acknowledges and writes the tail register. A design that mixed up queue state, reordered MSIs, or let software move the tail would write to the wrong address or raise the wrong irq bit.

// File: rtl/msi_evq_pkg.sv
package msi_evq_pkg;
    typedef enum logic [1:0] {
        FLD_BASE = 2'd0,
        FLD_HEAD = 2'd1,
        FLD_TAIL = 2'd2,
        FLD_NONE = 2'd3
    } evq_field_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_WRITE = 1'b1
    } wr_state_e;
endpackage

// File: rtl/evq_ptr_bank.sv
module evq_ptr_bank
    import msi_evq_pkg::*;
#(
    parameter int NQ  = 4,
    parameter int PW  = 6,
    parameter int AW  = 32,
    parameter int QIW = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_wr,
    input  logic [QIW-1:0]         cfg_q,
    input  evq_field_e             cfg_fld,
    input  logic [AW-1:0]          cfg_wdata,
    input  logic                   adv_en,
    input  logic [QIW-1:0]         adv_q,
    output logic [NQ-1:0][AW-1:0]  base_o,
    output logic [NQ-1:0][PW-1:0]  head_o,
    output logic [NQ-1:0][PW-1:0]  tail_o,
    output logic [NQ-1:0]          full_o,
    output logic [NQ-1:0]          pend_o
);
    typedef struct packed {
        logic [NQ-1:0][AW-1:0] base;
        logic [NQ-1:0][PW-1:0] head;
        logic [NQ-1:0][PW-1:0] tail;
    } bank_s;

    bank_s bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < NQ; i++) begin
            if (cfg_wr && cfg_q == QIW'(i)) begin
                case (cfg_fld)
                    FLD_BASE: bank_d.base[i] = cfg_wdata;
                    FLD_HEAD: bank_d.head[i] = cfg_wdata[PW-1:0];
                    default:  ;
                endcase
            end
            if (adv_en && adv_q == QIW'(i)) begin
                bank_d.tail[i] = bank_q.tail[i] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign base_o = bank_q.base;
    assign head_o = bank_q.head;
    assign tail_o = bank_q.tail;

    for (genvar g = 0; g < NQ; g++) begin : g_flag
        logic [PW-1:0] next_tail;
        assign next_tail = bank_q.tail[g] + 1'b1;
        assign full_o[g] = (next_tail == bank_q.head[g]);
        assign pend_o[g] = (bank_q.head[g] != bank_q.tail[g]);
    end

    // R9
    tail_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_fld == FLD_TAIL && !adv_en) |=> $stable(tail_o));
endmodule

// File: rtl/evq_write_ctl.sv
module evq_write_ctl
    import msi_evq_pkg::*;
#(
    parameter int NQ  = 4,
    parameter int AW  = 32,
    parameter int QIW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            msi_valid,
    input  logic [QIW-1:0]  msi_q,
    input  logic [15:0]     msi_data,
    input  logic [NQ-1:0]   q_full,
    input  logic [AW-1:0]   slot_addr,
    input  logic            mem_ack,
    output logic            msi_ready,
    output logic            mem_req,
    output logic [AW-1:0]   mem_addr,
    output logic [31:0]     mem_wdata,
    output logic            adv_en,
    output logic [QIW-1:0]  adv_q
);
    typedef struct packed {
        wr_state_e     st;
        logic [QIW-1:0] q;
        logic [AW-1:0]  addr;
        logic [15:0]    data;
    } ctl_s;

    ctl_s ctl_d, ctl_q;

    always_comb begin
        ctl_d     = ctl_q;
        msi_ready = (ctl_q.st == ST_IDLE) && !q_full[msi_q];
        adv_en    = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (msi_valid && msi_ready) begin
                    ctl_d.st   = ST_WRITE;
                    ctl_d.q    = msi_q;
                    ctl_d.addr = slot_addr;
                    ctl_d.data = msi_data;
                end
            end
            ST_WRITE: begin
                if (mem_ack) begin
                    adv_en   = 1'b1;
                    ctl_d.st = ST_IDLE;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign mem_req   = (ctl_q.st == ST_WRITE);
    assign mem_addr  = ctl_q.addr;
    assign mem_wdata = {16'h0000, ctl_q.data};
    assign adv_q     = ctl_q.q;

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)));
    // R4
    single_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> !mem_req);
    // R2
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_wdata[31:16] == 16'h0000));
endmodule

// File: rtl/msi_evq_writer.sv
module msi_evq_writer
    import msi_evq_pkg::*;
#(
    parameter int NQ    = 4,
    parameter int DEPTH = 64,
    parameter int AW    = 32,
    localparam int QIW  = (NQ > 1) ? $clog2(NQ) : 1,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            msi_valid,
    output logic            msi_ready,
    input  logic [QIW-1:0]  msi_queue,
    input  logic [15:0]     msi_data,
    output logic            mem_req,
    input  logic            mem_ack,
    output logic [AW-1:0]   mem_addr,
    output logic [31:0]     mem_wdata,
    input  logic            reg_wr,
    input  logic [QIW+1:0]  reg_addr,
    input  logic [AW-1:0]   reg_wdata,
    output logic [AW-1:0]   reg_rdata,
    output logic [NQ-1:0]   irq
);
    logic [NQ-1:0][AW-1:0] base_w;
    logic [NQ-1:0][PW-1:0] head_w;
    logic [NQ-1:0][PW-1:0] tail_w;
    logic [NQ-1:0]         full_w;
    logic [NQ-1:0]         pend_w;
    logic                  adv_en;
    logic [QIW-1:0]        adv_q;
    logic [AW-1:0]         slot_addr;
    logic [QIW-1:0]        rd_q;
    evq_field_e            rd_fld;

    assign rd_q   = reg_addr[QIW+1:2];
    assign rd_fld = evq_field_e'(reg_addr[1:0]);

    assign slot_addr = base_w[msi_queue] + AW'({tail_w[msi_queue], 2'b00});

    evq_ptr_bank #(.NQ(NQ), .PW(PW), .AW(AW), .QIW(QIW)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(reg_wr), .cfg_q(rd_q), .cfg_fld(rd_fld), .cfg_wdata(reg_wdata),
        .adv_en(adv_en), .adv_q(adv_q),
        .base_o(base_w), .head_o(head_w), .tail_o(tail_w),
        .full_o(full_w), .pend_o(pend_w)
    );

    evq_write_ctl #(.NQ(NQ), .AW(AW), .QIW(QIW)) u_ctl (
        .clk(clk), .rst_n(rst_n),
        .msi_valid(msi_valid), .msi_q(msi_queue), .msi_data(msi_data),
        .q_full(full_w), .slot_addr(slot_addr), .mem_ack(mem_ack),
        .msi_ready(msi_ready), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .adv_en(adv_en), .adv_q(adv_q)
    );

    always_comb begin
        reg_rdata = '0;
        case (rd_fld)
            FLD_BASE: reg_rdata = base_w[rd_q];
            FLD_HEAD: reg_rdata = AW'(head_w[rd_q]);
            FLD_TAIL: reg_rdata = AW'(tail_w[rd_q]);
            default:  reg_rdata = '0;
        endcase
    end

    assign irq = pend_w;

    for (genvar g = 0; g < NQ; g++) begin : g_irq_chk
        // R6
        irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq[g]) |-> ($past(mem_ack) || $past(reg_wr)));
        // R6
        irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(irq[g]) |-> $past(reg_wr));
    end
endmodule

// File: tb/sim_msi_evq_writer.sv
module sim_msi_evq_writer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msi_valid = 1'b0;
    logic        msi_ready;
    logic [1:0]  msi_queue = '0;
    logic [15:0] msi_data = '0;
    logic        mem_req;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  irq;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [31:0] log_addr [0:255];
    logic [31:0] log_data [0:255];
    int wr_cnt = 0;
    int ack_delay = 0;
    bit ack_hold = 0;
    int wait_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    msi_evq_writer u0 (
        .clk(clk), .rst_n(rst_n),
        .msi_valid(msi_valid), .msi_ready(msi_ready),
        .msi_queue(msi_queue), .msi_data(msi_data),
        .mem_req(mem_req), .mem_ack(mem_ack),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq)
    );

    // memory responder
    initial begin
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req && !ack_hold) begin
                if (wait_cnt >= ack_delay) begin
                    if (wr_cnt < 256) begin
                        log_addr[wr_cnt] = mem_addr;
                        log_data[wr_cnt] = mem_wdata;
                    end
                    wr_cnt++;
                    mem_ack = 1'b1;
                    wait_cnt = 0;
                end else begin
                    wait_cnt++;
                end
            end
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(int q, int f, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = {q[1:0], f[1:0]}; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(int q, int f, output logic [31:0] d);
        reg_addr = {q[1:0], f[1:0]};
        #1;
        d = reg_rdata;
    endtask

    task automatic send_msi(int q, logic [15:0] d);
        @(negedge clk);
        msi_valid = 1'b1; msi_queue = q[1:0]; msi_data = d;
        #1;
        while (!msi_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        @(negedge clk);
        msi_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (mem_req) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        @(negedge clk);
        chk("R1 irq", {28'h0, irq}, 32'h0);
        chk("R1 mem_req", {31'h0, mem_req}, 32'h0);
        msi_queue = 2'd0;
        #1;
        chk("R1 msi_ready", {31'h0, msi_ready}, 32'h1);
        for (int q = 0; q < 4; q++) begin
            reg_read(q, 2, v); chk("R1 tail", v, 32'h0);
            reg_read(q, 1, v); chk("R1 head", v, 32'h0);
        end
    endtask

    task automatic t_basic();
        logic [31:0] v;
        int idx;
        reg_write(1, 0, 32'h0000_1000);
        reg_read(1, 0, v); chk("R9 base readback", v, 32'h0000_1000);
        idx = wr_cnt;
        send_msi(1, 16'hBEEF); wait_idle();
        chk("R3 first addr", log_addr[idx], 32'h0000_1000);
        chk("R2 entry word", log_data[idx], 32'h0000_BEEF);
        reg_read(1, 2, v); chk("R3 tail step", v, 32'd1);
        chk("R6 R8 irq own bit", {28'h0, irq}, 32'h2);
        idx = wr_cnt;
        send_msi(1, 16'h1234); wait_idle();
        chk("R3 second addr", log_addr[idx], 32'h0000_1004);
        chk("R2 entry word 2", log_data[idx], 32'h0000_1234);
    endtask

    task automatic t_hold();
        logic [31:0] v;
        reg_write(2, 0, 32'h0000_2000);
        ack_hold = 1;
        send_msi(2, 16'h00AA);
        repeat (3) @(negedge clk);
        chk("R4 req held", {31'h0, mem_req}, 32'h1);
        chk("R4 addr held", mem_addr, 32'h0000_2000);
        msi_queue = 2'd0;
        #1;
        chk("R4 ready low while pending", {31'h0, msi_ready}, 32'h0);
        reg_read(2, 2, v); chk("R5 tail before ack", v, 32'h0);
        chk("R5 irq before ack", {31'h0, irq[2]}, 32'h0);
        ack_hold = 0;
        @(negedge clk);
        wait_idle();
        reg_read(2, 2, v); chk("R5 tail after ack", v, 32'h1);
        chk("R6 irq after ack", {31'h0, irq[2]}, 32'h1);
    endtask

    task automatic t_head();
        logic [31:0] v;
        reg_write(1, 1, 32'd2);
        chk("R6 irq clears at head==tail", {31'h0, irq[1]}, 32'h0);
        reg_write(1, 2, 32'd9);
        reg_read(1, 2, v); chk("R9 tail write ignored", v, 32'd2);
        reg_read(1, 3, v); chk("R9 field3 reads zero", v, 32'h0);
        reg_write(2, 1, 32'd1);
        chk("R6 irq2 clears", {28'h0, irq}, 32'h0);
    endtask

    task automatic t_order();
        int idx;
        reg_write(0, 0, 32'h8000_0000);
        reg_write(3, 0, 32'h0000_3000);
        ack_delay = 2;
        idx = wr_cnt;
        send_msi(0, 16'h0A01);
        send_msi(3, 16'h0B02);
        send_msi(2, 16'h0C03);
        send_msi(0, 16'h0D04);
        wait_idle();
        ack_delay = 0;
        chk("R8 order 0", log_addr[idx],     32'h8000_0000);
        chk("R8 order 1", log_addr[idx + 1], 32'h0000_3000);
        chk("R8 order 2", log_addr[idx + 2], 32'h0000_2004);
        chk("R8 order 3", log_addr[idx + 3], 32'h8000_0004);
        chk("R8 data order", log_data[idx + 2], 32'h0000_0C03);
        chk("R8 irq set", {28'h0, irq}, 32'hD);
    endtask

    task automatic t_full();
        logic [31:0] v;
        int t0, idx;
        reg_read(3, 2, v);
        t0 = int'(v);
        reg_write(3, 1, v);
        for (int j = 0; j < 63; j++) begin
            idx = wr_cnt;
            send_msi(3, 16'(j));
            wait_idle();
            if (((t0 + j) % 64) == 63 || ((t0 + j) % 64) == 0)
                chk("R3 wrap addr", log_addr[idx], 32'h0000_3000 + 32'(4 * ((t0 + j) % 64)));
        end
        reg_read(3, 2, v); chk("R7 tail after fill", v, 32'((t0 + 63) % 64));
        idx = wr_cnt;
        @(negedge clk);
        msi_valid = 1'b1; msi_queue = 2'd3; msi_data = 16'hFFFF;
        #1;
        chk("R7 ready low when full", {31'h0, msi_ready}, 32'h0);
        repeat (3) @(negedge clk);
        chk("R7 no write when full", 32'(wr_cnt - idx), 32'h0);
        chk("R7 no req when full", {31'h0, mem_req}, 32'h0);
        msi_valid = 1'b0;
        msi_queue = 2'd0;
        #1;
        chk("R7 other queue ready", {31'h0, msi_ready}, 32'h1);
        reg_write(3, 1, 32'((t0 + 1) % 64));
        msi_queue = 2'd3;
        #1;
        chk("R7 ready after head move", {31'h0, msi_ready}, 32'h1);
        idx = wr_cnt;
        send_msi(3, 16'h5A5A); wait_idle();
        chk("R7 R3 slot after release", log_addr[idx], 32'h0000_3000 + 32'(4 * ((t0 + 63) % 64)));
        reg_read(3, 2, v); chk("R7 tail after release", v, 32'(t0 % 64));
        chk("R6 irq3 still set", {31'h0, irq[3]}, 32'h1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_hold();
        t_head();
        t_order();
        t_full();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule